// File: doc/BRIEF.md
# Immediate-Offset Word Store Unit

This block takes one store-word instruction with an immediate offset and carries it out in a single clock step. A mode input selects between a fixed 32-bit instruction format and a compact format that mixes 16-bit and 32-bit instructions. The block decodes the word into a base register, a source register, a scaled immediate and three addressing controls (index, add, writeback). It reads both registers from an internal register file of sixteen 32-bit entries, forms the effective address, and drives a word-wide memory write port in the same cycle.

When writeback applies, the base register takes the offset address on the next clock edge. The decoder raises one of three exclusive flags for encodings that must not execute as a plain store: undefined, unpredictable, or hand-off to the unprivileged-store variant. A separate output marks the one instruction shape that is a single-register push. Condition evaluation happens outside the block and arrives on a pass input. A load port and a peek port on the register file let the surrounding pipeline set up and observe register state. Every legal store takes the same one cycle whatever data it carries.

Top module: `str_imm_unit`

## Requirements
- R1: Fixed format (mode_i=0) takes cond in [31:28] (not 1111), [27:25]=010, index bit P at [24], add bit U at [23], [22]=0, W at [21], [20]=0, base in [19:16], source in [15:12] and a zero-extended 12-bit offset in [11:0]. The offset address is base+offset when U=1 and base-offset when U=0. The memory address is the offset address when P=1 and the unmodified base when P=0. Writeback is enabled when P=0 or W=1.
- R2: In the fixed format, P=0 with W=1 raises redirect_o and issues no store and no writeback.
- R3: In the fixed format, writeback together with base 15, or with base equal to source, raises unpred_o and issues no store.
- R4: In the fixed format, a source of register 15 stores pc_plus8_i in place of the register value.
- R5: A compact 16-bit word with [15:11]=01100 takes base [5:3], source [2:0] and imm5 [10:6]. It stores to base+imm5*4 with no writeback.
- R6: A compact 16-bit word with [15:11]=10010 takes source [10:8] and imm8 [7:0]. It stores to register 13 + imm8*4 with no writeback.
- R7: A compact 32-bit word with [31:20]=111110001100 takes base [19:16], source [15:12] and a 12-bit offset [11:0]. It stores to base+offset with no writeback. Base 15 raises undef_o and source 15 raises unpred_o.
- R8: A compact 32-bit word with [31:20]=111110000100 and [11]=1 takes base [19:16], source [15:12], P [10], U [9], W [8] and imm8 [7:0], with index=P, add=U and writeback=W. P=1,U=1,W=0 raises redirect_o. Otherwise base 15, or P=0 with W=0, raises undef_o. Otherwise source 15, or W=1 with base equal to source, raises unpred_o.
- R9: push_alias_o is high for a legal pre-indexed, subtracting, writeback store on base 13 with offset 4, in either the fixed form or the compact form from R8, and low for any other offset.
- R10: When cond_pass_i is low, or any of undef_o, unpred_o or redirect_o is high, mem_we_o stays low and no register changes.
- R11: mem_we_o, mem_addr_o and mem_wdata_o reflect the instruction in the same cycle. The base register holds the offset address from the next rising edge on, which is visible on rf_peek_data_o.
- R12: len32_o is 1 for any fixed-format word and for a compact word whose [31:27] is 11101, 11110 or 11111. It is 0 for a compact 16-bit word, which sits in [15:0].
- R13: Any word matching none of the forms above, in either mode, raises undef_o and issues no store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; clears the register file |
| mode_i | input | 1 | 0 fixed 32-bit format, 1 compact format |
| instr_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition check result from outside |
| pc_plus8_i | input | 32 | Stored value when the fixed-format source is register 15 |
| rf_ld_en_i | input | 1 | Register load strobe |
| rf_ld_idx_i | input | 4 | Register load index |
| rf_ld_data_i | input | 32 | Register load value |
| rf_peek_idx_i | input | 4 | Register observe index |
| rf_peek_data_o | output | 32 | Register observe value |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| len32_o | output | 1 | Decoded instruction is 32-bit |
| undef_o | output | 1 | Undefined encoding |
| unpred_o | output | 1 | Unpredictable encoding |
| redirect_o | output | 1 | Belongs to the unprivileged-store variant |
| push_alias_o | output | 1 | Single-register push form |

## Verification
The bench targets post-indexed stores, where a design that used the offset address would write to base±offset instead of the old base. It also targets writeback, where a combinational update would show the new base in the same cycle or not at all. It checks the two forms that share the P, U and W bits but read them differently: a design that copied fixed-format rules into the compact form would accept P=0,W=0 and miss the redirect on P=1,U=1,W=0. Push detection is probed with offset 4 and with offset 8, which catches a design that ignores the offset. Gated stores, with the pass input low or a flag raised, are followed by a register peek, so that a hidden writeback shows up.

// File: rtl/str_imm_pkg.sv
package str_imm_pkg;
  localparam int unsigned XLEN = 32;
  localparam int unsigned NREG = 16;
  localparam int unsigned RIDX = $clog2(NREG);
  localparam logic [RIDX-1:0] SP_IDX = RIDX'(13);
  localparam logic [RIDX-1:0] PC_IDX = RIDX'(NREG - 1);

  typedef struct packed {
    logic [RIDX-1:0] rn;
    logic [RIDX-1:0] rt;
    logic [XLEN-1:0] imm;
    logic            index;
    logic            add;
    logic            wback;
    logic            len32;
    logic            undef;
    logic            unpred;
    logic            redirect;
    logic            push;
    logic            rt_is_pc;
  } dec_t;
endpackage

// File: rtl/str_imm_decode.sv
module str_imm_decode
  import str_imm_pkg::*;
(
  input  logic            mode_i,
  input  logic [31:0]     instr_i,
  output dec_t            dec_o
);
  logic [15:0] hw_hi, hw_lo;
  logic        p_b, u_b, w_b, is32;

  assign hw_hi = instr_i[31:16];
  assign hw_lo = instr_i[15:0];
  assign is32  = (hw_hi[15:11] == 5'b11101) || (hw_hi[15:11] == 5'b11110) ||
                 (hw_hi[15:11] == 5'b11111);

  always_comb begin
    dec_o = '0;
    p_b = 1'b0;
    u_b = 1'b0;
    w_b = 1'b0;
    if (!mode_i) begin
      dec_o.len32 = 1'b1;
      if (instr_i[31:28] == 4'hF || instr_i[27:25] != 3'b010 ||
          instr_i[22] || instr_i[20]) begin
        dec_o.undef = 1'b1;
      end else begin
        p_b = instr_i[24];
        u_b = instr_i[23];
        w_b = instr_i[21];
        dec_o.rn       = instr_i[19:16];
        dec_o.rt       = instr_i[15:12];
        dec_o.imm      = XLEN'(instr_i[11:0]);
        dec_o.index    = p_b;
        dec_o.add      = u_b;
        dec_o.wback    = !p_b || w_b;
        dec_o.rt_is_pc = (dec_o.rt == PC_IDX);
        dec_o.redirect = !p_b && w_b;
        dec_o.unpred   = !dec_o.redirect && dec_o.wback &&
                         (dec_o.rn == PC_IDX || dec_o.rn == dec_o.rt);
        dec_o.push     = !dec_o.unpred && p_b && !u_b && w_b &&
                         dec_o.rn == SP_IDX && instr_i[11:0] == 12'd4;
      end
    end else if (!is32) begin
      dec_o.len32 = 1'b0;
      dec_o.index = 1'b1;
      dec_o.add   = 1'b1;
      if (hw_lo[15:11] == 5'b01100) begin
        dec_o.rn  = RIDX'(hw_lo[5:3]);
        dec_o.rt  = RIDX'(hw_lo[2:0]);
        dec_o.imm = XLEN'({hw_lo[10:6], 2'b00});
      end else if (hw_lo[15:11] == 5'b10010) begin
        dec_o.rn  = SP_IDX;
        dec_o.rt  = RIDX'(hw_lo[10:8]);
        dec_o.imm = XLEN'({hw_lo[7:0], 2'b00});
      end else begin
        dec_o.undef = 1'b1;
      end
    end else begin
      dec_o.len32 = 1'b1;
      dec_o.rn    = hw_hi[3:0];
      dec_o.rt    = hw_lo[15:12];
      if (hw_hi[15:4] == 12'hF8C) begin
        dec_o.imm    = XLEN'(hw_lo[11:0]);
        dec_o.index  = 1'b1;
        dec_o.add    = 1'b1;
        dec_o.undef  = (dec_o.rn == PC_IDX);
        dec_o.unpred = !dec_o.undef && (dec_o.rt == PC_IDX);
      end else if (hw_hi[15:4] == 12'hF84 && hw_lo[11]) begin
        p_b = hw_lo[10];
        u_b = hw_lo[9];
        w_b = hw_lo[8];
        dec_o.imm      = XLEN'(hw_lo[7:0]);
        dec_o.index    = p_b;
        dec_o.add      = u_b;
        dec_o.wback    = w_b;
        dec_o.redirect = p_b && u_b && !w_b;
        dec_o.undef    = !dec_o.redirect &&
                         (dec_o.rn == PC_IDX || (!p_b && !w_b));
        dec_o.unpred   = !dec_o.redirect && !dec_o.undef &&
                         (dec_o.rt == PC_IDX || (w_b && dec_o.rn == dec_o.rt));
        dec_o.push     = !dec_o.redirect && !dec_o.undef && !dec_o.unpred &&
                         p_b && !u_b && w_b && dec_o.rn == SP_IDX &&
                         hw_lo[7:0] == 8'd4;
      end else begin
        dec_o.undef = 1'b1;
      end
    end
  end
endmodule

// File: rtl/str_imm_agu.sv
module str_imm_agu
  import str_imm_pkg::*;
(
  input  logic [XLEN-1:0] base_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            add_i,
  input  logic            index_i,
  output logic [XLEN-1:0] offs_o,
  output logic [XLEN-1:0] addr_o
);
  assign offs_o = add_i ? (base_i + imm_i) : (base_i - imm_i);
  assign addr_o = index_i ? offs_o : base_i;
endmodule

// File: rtl/str_imm_rf.sv
module str_imm_rf
  import str_imm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RIDX-1:0] rd_a_idx_i,
  output logic [XLEN-1:0] rd_a_o,
  input  logic [RIDX-1:0] rd_b_idx_i,
  output logic [XLEN-1:0] rd_b_o,
  input  logic [RIDX-1:0] rd_c_idx_i,
  output logic [XLEN-1:0] rd_c_o,
  input  logic            ld_en_i,
  input  logic [RIDX-1:0] ld_idx_i,
  input  logic [XLEN-1:0] ld_data_i,
  input  logic            wb_en_i,
  input  logic [RIDX-1:0] wb_idx_i,
  input  logic [XLEN-1:0] wb_data_i
);
  logic [XLEN-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // writeback takes precedence over an external load to the same entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   regs_q[g] <= '0;
      else if (wb_en_i && wb_idx_i == RIDX'(g))      regs_q[g] <= wb_data_i;
      else if (ld_en_i && ld_idx_i == RIDX'(g))      regs_q[g] <= ld_data_i;
    end
  end

  assign rd_a_o = regs_q[rd_a_idx_i];
  assign rd_b_o = regs_q[rd_b_idx_i];
  assign rd_c_o = regs_q[rd_c_idx_i];

  p_wb_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_i |=> regs_q[$past(wb_idx_i)] == $past(wb_data_i));
endmodule

// File: rtl/str_imm_unit.sv
module str_imm_unit
  import str_imm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mode_i,
  input  logic [31:0] instr_i,
  input  logic        cond_pass_i,
  input  logic [31:0] pc_plus8_i,
  input  logic        rf_ld_en_i,
  input  logic [3:0]  rf_ld_idx_i,
  input  logic [31:0] rf_ld_data_i,
  input  logic [3:0]  rf_peek_idx_i,
  output logic [31:0] rf_peek_data_o,
  output logic        mem_we_o,
  output logic [31:0] mem_addr_o,
  output logic [31:0] mem_wdata_o,
  output logic        len32_o,
  output logic        undef_o,
  output logic        unpred_o,
  output logic        redirect_o,
  output logic        push_alias_o
);
  dec_t            dec;
  logic [XLEN-1:0] base_val, src_val, offs_addr;
  logic            exec, wb_en;

  str_imm_decode u_dec (
    .mode_i (mode_i),
    .instr_i(instr_i),
    .dec_o  (dec)
  );

  str_imm_rf u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_a_idx_i(dec.rn),
    .rd_a_o    (base_val),
    .rd_b_idx_i(dec.rt),
    .rd_b_o    (src_val),
    .rd_c_idx_i(rf_peek_idx_i),
    .rd_c_o    (rf_peek_data_o),
    .ld_en_i   (rf_ld_en_i),
    .ld_idx_i  (rf_ld_idx_i),
    .ld_data_i (rf_ld_data_i),
    .wb_en_i   (wb_en),
    .wb_idx_i  (dec.rn),
    .wb_data_i (offs_addr)
  );

  str_imm_agu u_agu (
    .base_i (base_val),
    .imm_i  (dec.imm),
    .add_i  (dec.add),
    .index_i(dec.index),
    .offs_o (offs_addr),
    .addr_o (mem_addr_o)
  );

  assign exec         = cond_pass_i && !dec.undef && !dec.unpred && !dec.redirect;
  assign wb_en        = exec && dec.wback;
  assign mem_we_o     = exec;
  assign mem_wdata_o  = dec.rt_is_pc ? pc_plus8_i : src_val;
  assign len32_o      = dec.len32;
  assign undef_o      = dec.undef;
  assign unpred_o     = dec.unpred;
  assign redirect_o   = dec.redirect;
  assign push_alias_o = dec.push;

  p_one_flag_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({undef_o, unpred_o, redirect_o}));
  p_push_legal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_alias_o |-> !undef_o && !unpred_o && !redirect_o);
  p_short_no_wb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !len32_o |-> !wb_en);
  p_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_pass_i |-> !mem_we_o && !wb_en);
  p_pc_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mode_i && instr_i[15:12] == 4'hF) |-> mem_wdata_o == pc_plus8_i);
endmodule

// File: tb/str_imm_unit_tb_top.sv
module str_imm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b0;
  logic [31:0] instr = '0;
  logic        cond_pass = 1'b0;
  logic [31:0] pc8 = 32'h0000_0108;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  peek_idx = '0;
  logic [31:0] peek_data, mem_addr, mem_wdata;
  logic        mem_we, len32, undef, unpred, redir, push;

  always #10 clk = ~clk;

  str_imm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .instr_i(instr),
    .cond_pass_i(cond_pass), .pc_plus8_i(pc8),
    .rf_ld_en_i(ld_en), .rf_ld_idx_i(ld_idx), .rf_ld_data_i(ld_data),
    .rf_peek_idx_i(peek_idx), .rf_peek_data_o(peek_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .len32_o(len32), .undef_o(undef), .unpred_o(unpred),
    .redirect_o(redir), .push_alias_o(push)
  );

  typedef struct {
    bit          is_reg;
    logic [31:0] val;
    logic        we;
    logic [31:0] addr;
    logic [4:0]  flags; // len32, undef, unpred, redirect, push
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  function automatic logic [31:0] enc_f(logic [3:0] c, logic p, logic u, logic w,
                                        logic [3:0] rn, logic [3:0] rt, logic [11:0] imm);
    return {c, 3'b010, p, u, 1'b0, w, 1'b0, rn, rt, imm};
  endfunction
  function automatic logic [31:0] enc_c3(logic [3:0] rn, logic [3:0] rt, logic [11:0] imm);
    return {12'hF8C, rn, rt, imm};
  endfunction
  function automatic logic [31:0] enc_c4(logic [3:0] rn, logic [3:0] rt, logic p, logic u,
                                         logic w, logic [7:0] imm);
    return {12'hF84, rn, rt, 1'b1, p, u, w, imm};
  endfunction

  task automatic st(input logic md, input logic [31:0] ins, input logic cp,
                    input logic we, input logic [31:0] addr, input logic [31:0] data,
                    input logic [4:0] flags, input string tag);
    exp_t e;
    @(posedge clk); #2;
    ld_en = 1'b0; mode = md; instr = ins; cond_pass = cp;
    e.is_reg = 1'b0; e.val = data; e.we = we; e.addr = addr; e.flags = flags; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk_reg(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    exp_t e;
    @(posedge clk); #2;
    ld_en = 1'b0; cond_pass = 1'b0; peek_idx = idx;
    e.is_reg = 1'b1; e.val = exp; e.we = 1'b0; e.addr = '0; e.flags = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] d);
    @(posedge clk); #2;
    cond_pass = 1'b0; ld_en = 1'b1; ld_idx = idx; ld_data = d;
  endtask

  // monitor: compares mid-cycle, after the driver settled the inputs
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (e.is_reg) begin
          if (peek_data !== e.val) begin
            n_fail++;
            $display("FAIL %s: reg act=%h exp=%h", e.tag, peek_data, e.val);
          end
        end else if (mem_we !== e.we ||
                     {len32, undef, unpred, redir, push} !== e.flags ||
                     (e.we && (mem_addr !== e.addr || mem_wdata !== e.val))) begin
          n_fail++;
          $display("FAIL %s: act we=%b flags=%b addr=%h data=%h exp we=%b flags=%b addr=%h data=%h",
                   e.tag, mem_we, {len32, undef, unpred, redir, push}, mem_addr, mem_wdata,
                   e.we, e.flags, e.addr, e.val);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: act=hung exp=finished");
    finish_run();
  end

  localparam logic [4:0] F32 = 5'b10000, F16 = 5'b00000;
  localparam logic [4:0] UND = 5'b01000, UNP = 5'b00100, RED = 5'b00010, PSH = 5'b00001;

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_ni = 1'b1;
    chk_reg(4'd1, 32'h0, "R11 reset");
    st(1'b0, enc_f(4'hE, 1, 1, 0, 4'd1, 4'd2, 12'h010), 1'b0, 1'b0, '0, '0, F32, "R10 reset idle");
    load(4'd1, 32'h0000_1000);
    load(4'd2, 32'hAABB_CCDD);
    load(4'd3, 32'h0000_2000);
    load(4'd5, 32'h1122_3344);
    load(4'd13, 32'h0000_8000);
    // fixed format
    st(1'b0, enc_f(4'hE, 1, 1, 0, 4'd1, 4'd2, 12'h010), 1'b1, 1'b1, 32'h1010, 32'hAABB_CCDD, F32, "R1 offset add");
    chk_reg(4'd1, 32'h1000, "R1 offset no wb");
    st(1'b0, enc_f(4'hE, 1, 0, 1, 4'd3, 4'd5, 12'h020), 1'b1, 1'b1, 32'h1FE0, 32'h1122_3344, F32, "R1 pre sub wb");
    chk_reg(4'd3, 32'h1FE0, "R11 pre wb next edge");
    st(1'b0, enc_f(4'hE, 0, 1, 0, 4'd1, 4'd2, 12'h008), 1'b1, 1'b1, 32'h1000, 32'hAABB_CCDD, F32, "R1 post index");
    chk_reg(4'd1, 32'h1008, "R11 post wb");
    st(1'b0, enc_f(4'hE, 0, 1, 1, 4'd1, 4'd2, 12'h008), 1'b1, 1'b0, '0, '0, F32 | RED, "R2 redirect");
    chk_reg(4'd1, 32'h1008, "R2 no wb");
    st(1'b0, enc_f(4'hE, 1, 1, 1, 4'd2, 4'd2, 12'h004), 1'b1, 1'b0, '0, '0, F32 | UNP, "R3 rn eq rt");
    st(1'b0, enc_f(4'hE, 0, 1, 0, 4'd15, 4'd2, 12'h004), 1'b1, 1'b0, '0, '0, F32 | UNP, "R3 rn pc");
    st(1'b0, enc_f(4'hE, 1, 1, 0, 4'd1, 4'd15, 12'h004), 1'b1, 1'b1, 32'h100C, 32'h0000_0108, F32, "R4 pc data");
    st(1'b0, enc_f(4'hE, 1, 0, 1, 4'd3, 4'd5, 12'h020), 1'b0, 1'b0, '0, '0, F32, "R10 cond fail");
    chk_reg(4'd3, 32'h1FE0, "R10 no wb");
    st(1'b0, enc_f(4'hF, 1, 1, 0, 4'd1, 4'd2, 12'h0), 1'b1, 1'b0, '0, '0, F32 | UND, "R13 cond 1111");
    st(1'b0, enc_f(4'hE, 1, 1, 0, 4'd1, 4'd2, 12'h0) | 32'h0200_0000, 1'b1, 1'b0, '0, '0, F32 | UND, "R13 class");
    st(1'b0, enc_f(4'hE, 1, 1, 0, 4'd1, 4'd2, 12'h0) | 32'h0040_0000, 1'b1, 1'b0, '0, '0, F32 | UND, "R13 byte bit");
    // compact 16-bit
    st(1'b1, {16'h0, 5'b01100, 5'd3, 3'd1, 3'd5}, 1'b1, 1'b1, 32'h1014, 32'h1122_3344, F16, "R5 short reg base");
    chk_reg(4'd1, 32'h1008, "R5 no wb");
    st(1'b1, {16'h0, 5'b10010, 3'd2, 8'h10}, 1'b1, 1'b1, 32'h8040, 32'hAABB_CCDD, F16, "R6 short sp base");
    chk_reg(4'd13, 32'h8000, "R6 no wb");
    // compact 32-bit
    st(1'b1, enc_c3(4'd1, 4'd2, 12'hFFF), 1'b1, 1'b1, 32'h2007, 32'hAABB_CCDD, F32, "R7 wide offset");
    st(1'b1, enc_c3(4'd15, 4'd2, 12'h4), 1'b1, 1'b0, '0, '0, F32 | UND, "R7 rn pc");
    st(1'b1, enc_c3(4'd1, 4'd15, 12'h4), 1'b1, 1'b0, '0, '0, F32 | UNP, "R7 rt pc");
    st(1'b1, enc_c4(4'd3, 4'd5, 1, 0, 1, 8'h10), 1'b1, 1'b1, 32'h1FD0, 32'h1122_3344, F32, "R8 pre sub wb");
    chk_reg(4'd3, 32'h1FD0, "R8 wb");
    st(1'b1, enc_c4(4'd1, 4'd2, 0, 1, 1, 8'h04), 1'b1, 1'b1, 32'h1008, 32'hAABB_CCDD, F32, "R8 post");
    chk_reg(4'd1, 32'h100C, "R8 post wb");
    st(1'b1, enc_c4(4'd1, 4'd2, 1, 0, 0, 8'h08), 1'b1, 1'b1, 32'h1004, 32'hAABB_CCDD, F32, "R8 neg offset");
    st(1'b1, enc_c4(4'd1, 4'd2, 1, 1, 0, 8'h08), 1'b1, 1'b0, '0, '0, F32 | RED, "R8 redirect");
    st(1'b1, enc_c4(4'd15, 4'd2, 1, 1, 0, 8'h08), 1'b1, 1'b0, '0, '0, F32 | RED, "R8 redirect over rn pc");
    st(1'b1, enc_c4(4'd1, 4'd2, 0, 1, 0, 8'h08), 1'b1, 1'b0, '0, '0, F32 | UND, "R8 p0 w0");
    st(1'b1, enc_c4(4'd15, 4'd2, 1, 0, 1, 8'h08), 1'b1, 1'b0, '0, '0, F32 | UND, "R8 rn pc");
    st(1'b1, enc_c4(4'd2, 4'd2, 1, 1, 1, 8'h08), 1'b1, 1'b0, '0, '0, F32 | UNP, "R8 rn eq rt");
    st(1'b1, enc_c4(4'd1, 4'd15, 1, 1, 1, 8'h08), 1'b1, 1'b0, '0, '0, F32 | UNP, "R8 rt pc");
    chk_reg(4'd1, 32'h100C, "R10 flagged no wb");
    // push form
    st(1'b0, enc_f(4'hE, 1, 0, 1, 4'd13, 4'd5, 12'h004), 1'b1, 1'b1, 32'h7FFC, 32'h1122_3344, F32 | PSH, "R9 push fixed");
    chk_reg(4'd13, 32'h7FFC, "R9 push wb");
    st(1'b1, enc_c4(4'd13, 4'd2, 1, 0, 1, 8'h04), 1'b1, 1'b1, 32'h7FF8, 32'hAABB_CCDD, F32 | PSH, "R9 push compact");
    st(1'b0, enc_f(4'hE, 1, 0, 1, 4'd13, 4'd5, 12'h008), 1'b1, 1'b1, 32'h7FF0, 32'h1122_3344, F32, "R9 not push");
    chk_reg(4'd13, 32'h7FF0, "R9 wb");
    // unknown compact words and length
    st(1'b1, 32'h0000_0000, 1'b1, 1'b0, '0, '0, F16 | UND, "R12 R13 short unknown");
    st(1'b1, 32'hF000_0000, 1'b1, 1'b0, '0, '0, F32 | UND, "R12 R13 wide unknown");
    st(1'b1, enc_c4(4'd1, 4'd2, 1, 0, 1, 8'h04) & 32'hFFFF_F7FF, 1'b1, 1'b0, '0, '0, F32 | UND, "R13 bit11 clear");
    chk_reg(4'd1, 32'h100C, "R13 no wb");
    @(posedge clk);
    @(posedge clk);
    finish_run();
  end
endmodule